// File: doc/BRIEF.md
# Strobed Result-Word Link Transmitter

This block sends quantized measurement results from an instrument back to a central controller over a 16-bit slice of a parallel digital port. The controller samples the link on the edges of a free-running strobe, so the transmitter makes that strobe itself. It divides the local clock to get a square wave that toggles on a fixed time grid, and it changes the data pins only in the same clock cycle as a strobe edge. The skew between strobe, valid and data is therefore the flop-to-pad skew and nothing more.

Results arrive 10 bits wide from an upstream source over a ready/valid handshake. Every strobe edge is a possible transfer slot. A programmable divisor limits transfers to every Nth edge, which keeps the word rate an integer fraction of the highest rate. The block asks for a word only in the cycle just before a slot edge. If a word is waiting, it is placed on the result pins and the valid indicator is raised on two duplicate pins. Otherwise valid drops and the result pins keep their last value. When the link is disabled, every pin is low. On enable, the strobe starts from a fixed low phase, so its delay from the clock is the same on every activation.

Top module: `result_link_tx`

## Requirements
- R1: While enabled, the strobe on port bit 15 toggles exactly once every STROBE_HALF clock cycles, so its period is 2*STROBE_HALF cycles.
- R2: While `link_en` is low, and in reset, all 16 port bits are low. After enable, the strobe stays low and first rises on the STROBE_HALF-th rising clock edge that samples `link_en` high.
- R3: Slot edges are the first strobe edge after enable and then every Nth strobe edge, where N is `slot_div` and a value of 0 acts as 1. `slot_div` is held steady while the link is enabled.
- R4: `res_ready` is high only in the single clock cycle that ends with a slot edge, and in that cycle it is always high.
- R5: A word accepted in that cycle (`res_valid` and `res_ready` both high) appears at the slot edge on port bits 10:1, with result bit i on port bit i+1, and the valid indicator goes high on port bit 0.
- R6: At a slot edge with no word pending, the valid indicator goes low and port bits 10:1 keep their previous value.
- R7: Between slot edges, the valid indicator and port bits 10:1 do not change. Any change to them happens in the same clock cycle as a strobe toggle.
- R8: Port bits 13:11 are always low, and port bit 14 always equals port bit 0.
- R9: With N equal to 1 and a source that is always ready, words go out in consecutive slots, one on every strobe edge, with valid high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; all outputs are registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Enables the link; low clears the strobe phase and all pins |
| slot_div | input | DIV_W | Strobe edges per transfer slot (0 acts as 1) |
| res_valid | input | 1 | Upstream result word is available |
| res_data | input | RESULT_W | Upstream result word, one bit per readout path |
| res_ready | output | 1 | Word is taken in this cycle (cycle before a slot edge) |
| dio_out | output | 16 | Port slice: strobe, duplicated valid, result bits, reserved zeros |

## Verification
The bench runs several divisor settings: 1, 0 (which must act as 1), small odd values and the largest value. Each runs with a source that is always full, always empty, or random. A cycle model built from the requirements predicts every pin at every clock. A phase error in the strobe counter shows up as a toggle one cycle early or late. A slot counter that wraps wrongly, or ignores the zero case, asks for words on the wrong edges. A transmitter that clears data on empty slots, or lets valid move between strobe edges, breaks the hold checks. The link is also disabled and re-enabled in the middle of a run, to catch a strobe that does not restart from low or pins that are not cleared.

// File: rtl/result_link_pkg.sv
package result_link_pkg;
   // Port slice layout; the far end decodes these positions.
   localparam int PORT_W      = 16;
   localparam int PIN_VLD_A   = 0;
   localparam int PIN_RES_LO  = 1;
   localparam int RES_BITS    = 10;
   localparam int PIN_RSV_LO  = 11;
   localparam int PIN_RSV_HI  = 13;
   localparam int RSV_BITS    = PIN_RSV_HI - PIN_RSV_LO + 1;
   localparam int PIN_VLD_B   = 14;
   localparam int PIN_STROBE  = 15;
endpackage

// File: rtl/rlt_strobe_gen.sv
module rlt_strobe_gen #(
   parameter int HALF = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic strobe,
   output logic edge_tick
);
   if (HALF < 1) begin : g_bad_half
      $error("rlt_strobe_gen: HALF must be at least 1");
   end

   if (HALF == 1) begin : g_every_cycle
      assign edge_tick = en;
   end else begin : g_counter
      localparam int CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] half_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                half_cnt <= '0;
         else if (!en)              half_cnt <= '0;
         else if (half_cnt == LAST) half_cnt <= '0;
         else                       half_cnt <= half_cnt + 1'b1;
      end

      assign edge_tick = en && (half_cnt == LAST);

      // R1
      half_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         half_cnt <= LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         strobe <= 1'b0;
      else if (!en)       strobe <= 1'b0;
      else if (edge_tick) strobe <= ~strobe;
   end

   // R2
   strobe_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !strobe);
endmodule

// File: rtl/rlt_slot_sched.sv
module rlt_slot_sched #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             edge_tick,
   input  logic [DIV_W-1:0] div,
   output logic             fire
);
   if (DIV_W < 1) begin : g_bad_div
      $error("rlt_slot_sched: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] edge_cnt;
   logic [DIV_W-1:0] last_idx;

   assign last_idx = (div == '0) ? '0 : div - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      edge_cnt <= '0;
      else if (!en)    edge_cnt <= '0;
      else if (edge_tick)
         edge_cnt <= (edge_cnt >= last_idx) ? '0 : edge_cnt + 1'b1;
   end

   assign fire = edge_tick && (edge_cnt == '0);

   // R3
   edge_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> edge_cnt <= last_idx);
endmodule

// File: rtl/rlt_word_reg.sv
module rlt_word_reg #(
   parameter int RESULT_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                load,
   input  logic                in_valid,
   input  logic [RESULT_W-1:0] in_data,
   output logic                valid_q,
   output logic [RESULT_W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (!en) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (load) begin
         valid_q <= in_valid;
         if (in_valid) data_q <= in_data;
      end
   end

   // R7
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load) |=> ($stable(data_q) && $stable(valid_q)));
endmodule

// File: rtl/result_link_tx.sv
module result_link_tx
   import result_link_pkg::*;
#(
   parameter int STROBE_HALF = 5,
   parameter int DIV_W       = 4,
   parameter int RESULT_W    = RES_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                link_en,
   input  logic [DIV_W-1:0]    slot_div,
   input  logic                res_valid,
   input  logic [RESULT_W-1:0] res_data,
   output logic                res_ready,
   output logic [PORT_W-1:0]   dio_out
);
   if (RESULT_W != RES_BITS) begin : g_bad_width
      $error("result_link_tx: RESULT_W must match the fixed pin map");
   end

   logic                strobe;
   logic                edge_tick;
   logic                slot_fire;
   logic                vld_q;
   logic [RESULT_W-1:0] word_q;

   rlt_strobe_gen #(.HALF(STROBE_HALF)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (link_en),
      .strobe    (strobe),
      .edge_tick (edge_tick)
   );

   rlt_slot_sched #(.DIV_W(DIV_W)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (link_en),
      .edge_tick (edge_tick),
      .div       (slot_div),
      .fire      (slot_fire)
   );

   rlt_word_reg #(.RESULT_W(RESULT_W)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (link_en),
      .load     (slot_fire),
      .in_valid (res_valid),
      .in_data  (res_data),
      .valid_q  (vld_q),
      .data_q   (word_q)
   );

   assign res_ready = slot_fire;

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (i == PIN_VLD_A || i == PIN_VLD_B) begin : g_vld
         assign dio_out[i] = vld_q;
      end else if (i == PIN_STROBE) begin : g_stb
         assign dio_out[i] = strobe;
      end else if (i >= PIN_RES_LO && i < PIN_RES_LO + RESULT_W) begin : g_res
         assign dio_out[i] = word_q[i - PIN_RES_LO];
      end else begin : g_rsv
         assign dio_out[i] = 1'b0;
      end
   end

   // R8
   rsv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dio_out[PIN_RSV_HI:PIN_RSV_LO] == '0);

   // R8
   vld_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dio_out[PIN_VLD_A] == dio_out[PIN_VLD_B]);

   // R4
   ready_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready |=> (dio_out[PIN_STROBE] != $past(dio_out[PIN_STROBE])));

   // R2
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_en |=> (dio_out == '0));
endmodule

// File: tb/result_link_tx_tb.sv
module result_link_tx_tb;
   localparam int HALF  = 5;
   localparam int DIV_W = 4;
   localparam int RW    = 10;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             link_en;
   logic [DIV_W-1:0] slot_div;
   logic             res_valid;
   logic [RW-1:0]    res_data;
   logic             res_ready;
   logic [15:0]      dio_out;

   always #2 clk = ~clk;

   result_link_tx #(.STROBE_HALF(HALF), .DIV_W(DIV_W), .RESULT_W(RW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_en   (link_en),
      .slot_div  (slot_div),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_ready (res_ready),
      .dio_out   (dio_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit          en_prev = 1'b0;
   bit          rdy_prev = 1'b0;
   bit          hs_prev = 1'b0;
   logic [RW-1:0] word_prev = '0;
   int          since = 0;
   int          edge_idx = 0;
   int          ndiv = 1;
   bit          exp_strobe = 1'b0;
   bit          exp_valid = 1'b0;
   logic [RW-1:0] exp_data = '0;

   function automatic int eff_div(input logic [DIV_W-1:0] d);
      return (d == '0) ? 1 : int'(d);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cycle(input bit en_next, input int vprob);
      logic [15:0] p;
      bit tog, slot;
      string lbl;
      @(negedge clk);
      p = dio_out;
      chk(p[13:11] == 3'b000, "R8", int'(p[13:11]), 0);
      chk(p[0] == p[14], "R8", int'(p[14]), int'(p[0]));
      if (!en_prev) begin
         chk(p == 16'h0, "R2", int'(p), 0);
      end else begin
         since++;
         if (edge_idx == 0 && since < HALF) chk(p[15] == 1'b0, "R2", int'(p[15]), 0);
         tog = (p[15] != exp_strobe);
         chk(tog == (since == HALF), "R1", int'(tog), int'(since == HALF));
         slot = 1'b0;
         if (since == HALF) begin
            exp_strobe = ~exp_strobe;
            since = 0;
            slot = ((edge_idx % ndiv) == 0);
            edge_idx++;
         end
         chk(rdy_prev == slot, slot ? "R3" : "R4", int'(rdy_prev), int'(slot));
         if (slot && hs_prev) begin
            exp_valid = 1'b1;
            exp_data  = word_prev;
            lbl = (ndiv == 1) ? "R9" : "R5";
         end else if (slot) begin
            exp_valid = 1'b0;
            lbl = "R6";
         end else begin
            lbl = "R7";
         end
         chk(p[0] == exp_valid, lbl, int'(p[0]), int'(exp_valid));
         chk(p[10:1] == exp_data, lbl, int'(p[10:1]), int'(exp_data));
      end
      if (en_next && !link_en) begin
         since = 0; edge_idx = 0; exp_strobe = 1'b0;
         exp_valid = 1'b0; exp_data = '0;
         ndiv = eff_div(slot_div);
      end
      link_en = en_next;
      if (!res_valid || hs_prev) begin
         res_valid = (($urandom % 100) < vprob);
         res_data  = RW'($urandom);
      end
      #1;
      rdy_prev  = res_ready;
      hs_prev   = res_ready && res_valid;
      word_prev = res_data;
      en_prev   = en_next && rst_n;
   endtask

   task automatic run(input logic [DIV_W-1:0] d, input int vprob, input int n);
      cycle(1'b0, 0);
      cycle(1'b0, 0);
      slot_div = d;
      cycle(1'b0, 0);
      for (int i = 0; i < n; i++) cycle(1'b1, vprob);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      rst_n = 1'b0; link_en = 1'b0; slot_div = 4'd1;
      res_valid = 1'b0; res_data = '0;
      for (int i = 0; i < 3; i++) cycle(1'b0, 0);   // reset state (R2)
      rst_n = 1'b1;
      run(4'd1, 100, 200);   // back-to-back every edge (R9)
      run(4'd1, 0, 100);     // empty slots hold data (R6)
      run(4'd2, 50, 300);
      run(4'd3, 70, 300);
      run(4'd0, 60, 200);    // zero acts as one (R3)
      run(4'd15, 80, 600);   // largest divisor
      run(4'd4, 100, 300);
      for (int k = 0; k < 5; k++) begin
         run(DIV_W'($urandom % 16), int'($urandom % 101), 250);
      end
      run(4'd2, 90, 57);     // drop enable mid-slot, then restart
      run(4'd2, 90, 150);
      cycle(1'b0, 0);
      cycle(1'b0, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule